// File: doc/BRIEF.md
# Stuck Bus Timeout Recovery Sequencer

This block watches the clock and data lines of the downstream segment of a two-wire bus buffer. Each line has its own low-time counter. When either line has been held low for too long, the block raises a fault flag that the connection controller uses to split the upstream and downstream segments. It then tries to free the segment. After a settling gap it toggles the clock line through its own open-drain pull-down for a bounded number of pulses, and stops pulsing as soon as both lines read high. It always closes with a stop condition.

If the segment is still held low once the stop condition is done, the fault stays up and the block drives nothing until both lines read high together. Driving ENABLE low cancels any recovery at once. A new rising edge of ENABLE restarts the low-time counters, which keep running. All intervals are counted in ticks of a clock-enable input, and every length is a parameter. The block starts counting as soon as reset is released, so a segment that is already stuck at power-up is recovered in the same way.

Top module: `stuck_bus_recovery`

## Requirements
- R1: While reset is active and straight after it, `fault_o`, `scl_pd_o`, `sda_pd_o` and `acc_inh_o` are all 0.
- R2: Each line has its own counter. With `tick_en` high, `fault_o` goes to 1 in the cycle after the counter has seen STUCK_TICKS consecutive low samples on either line. This is STUCK_TICKS+1 clock edges after the first low sample.
- R3: A single high sample clears that line's counter. A low run of STUCK_TICKS-1 samples, then one high sample, raises no fault, and a new full run is needed.
- R4: `fault_o` rises, and then `scl_pd_o` (1 = pull low) first rises exactly GAP_TICKS cycles later.
- R5: Each recovery pulse pulls the clock low for HALF_TICKS cycles and releases it for HALF_TICKS cycles. There are never more than NUM_PULSES pulses.
- R6: If both lines read high during a release half, pulsing ends and no further pulse starts.
- R7: A stop condition always follows the pulsing. SDA is pulled low only while SCL is already pulled low. SCL is released while SDA is still held. SDA is released last. Each step lasts STOP_TICKS cycles.
- R8: After the stop, `fault_o` clears one cycle after both lines read high. While a line stays low, `fault_o` stays 1 and neither pull-down is driven.
- R9: When `en_lvl` is low, all four outputs are 0 one cycle later and no recovery starts, even on a stuck line.
- R10: A rising edge of `en_lvl` restarts both counters. On a line that stays low, `fault_o` rises STUCK_TICKS+2 cycles after `en_lvl` is raised.
- R11: `acc_inh_o` is 1 whenever a pull-down is driven, and it is 0 whenever `fault_o` is 0.
- R12: While `tick_en` is 0, the counters and the sequence do not advance.
- R13: If a line is already low when reset is released, `fault_o` rises STUCK_TICKS+1 cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted until lockout ends |
| tick_en | input | 1 | Timebase enable; every interval is counted in these ticks |
| en_lvl | input | 1 | Enable level; low cancels recovery, a rising edge restarts the counters |
| scl_lvl | input | 1 | Sampled level of the downstream clock line |
| sda_lvl | input | 1 | Sampled level of the downstream data line |
| fault_o | output | 1 | Stuck fault; tells the connection controller to disconnect |
| scl_pd_o | output | 1 | Pull-down control for the clock line (1 = pull low) |
| sda_pd_o | output | 1 | Pull-down control for the data line (1 = pull low) |
| acc_inh_o | output | 1 | Inhibit for the rise-time accelerators |

## Verification
The fault flag rises STUCK_TICKS+1 edges after the first low sample, or STUCK_TICKS+2 edges after ENABLE is raised, because the restart uses up one edge. The first pull-down follows GAP_TICKS edges later. Each phase then lasts its own count, and the flag clears one edge after both lines read high. The bench drives inputs and samples outputs only at falling clock edges. It measures each of these latencies by counting falling edges from the stimulus to the observed change, and compares each count with the value worked out from the parameters.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   // Recovery sequence phases
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_CLK_LO,
      ST_CLK_HI,
      ST_STOP_A,   // SCL low, SDA released
      ST_STOP_B,   // SCL low, SDA low
      ST_STOP_C,   // SCL released, SDA low
      ST_HOLD      // waiting for both lines high
   } rec_state_t;
endpackage

// File: rtl/sbr_low_timer.sv
module sbr_low_timer #(
   parameter int LIMIT = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   input  logic line_lvl,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (tick_en) begin
         if (line_lvl)
            cnt <= '0;
         else if (cnt != LIM_V)
            cnt <= cnt + 1'b1;
      end
   end

   assign expired = (cnt == LIM_V);
endmodule

// File: rtl/sbr_recovery_fsm.sv
module sbr_recovery_fsm
   import sbr_pkg::*;
#(
   parameter int GAP_TICKS  = 40,
   parameter int HALF_TICKS = 59,
   parameter int NUM_PULSES = 16,
   parameter int STOP_TICKS = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic en_lvl,
   input  logic en_rise,
   input  logic stuck,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic fault,
   output logic scl_pd,
   output logic sda_pd,
   output logic acc_inh
);
   localparam int PMAX0 = (GAP_TICKS > HALF_TICKS) ? GAP_TICKS : HALF_TICKS;
   localparam int PMAX  = (PMAX0 > STOP_TICKS) ? PMAX0 : STOP_TICKS;
   localparam int PW    = $clog2(PMAX + 1);
   localparam int NW    = $clog2(NUM_PULSES + 1);
   localparam logic [NW-1:0] NP_V = NW'(NUM_PULSES);

   rec_state_t    st;
   logic [PW-1:0] pc;
   logic [PW-1:0] lim_m1;
   logic [NW-1:0] np;
   logic          phase_done;
   logic          bus_free;

   assign bus_free = scl_lvl & sda_lvl;

   always_comb begin
      case (st)
         ST_GAP:                          lim_m1 = PW'(GAP_TICKS - 1);
         ST_CLK_LO, ST_CLK_HI:            lim_m1 = PW'(HALF_TICKS - 1);
         ST_STOP_A, ST_STOP_B, ST_STOP_C: lim_m1 = PW'(STOP_TICKS - 1);
         default:                         lim_m1 = '0;
      endcase
   end

   assign phase_done = (pc == lim_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         pc <= '0;
         np <= '0;
      end else if (!en_lvl) begin
         st <= ST_IDLE;
         pc <= '0;
         np <= '0;
      end else if (tick_en) begin
         case (st)
            ST_IDLE: begin
               if (stuck && !en_rise) begin
                  st <= ST_GAP;
                  pc <= '0;
               end
            end
            ST_GAP: begin
               if (phase_done) begin
                  pc <= '0;
                  np <= '0;
                  st <= bus_free ? ST_STOP_A : ST_CLK_LO;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_CLK_LO: begin
               if (phase_done) begin
                  pc <= '0;
                  np <= np + 1'b1;
                  st <= ST_CLK_HI;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_CLK_HI: begin
               if (bus_free) begin
                  pc <= '0;
                  st <= ST_STOP_A;
               end else if (phase_done) begin
                  pc <= '0;
                  st <= (np == NP_V) ? ST_STOP_A : ST_CLK_LO;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_STOP_A: begin
               if (phase_done) begin
                  pc <= '0;
                  st <= ST_STOP_B;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_STOP_B: begin
               if (phase_done) begin
                  pc <= '0;
                  st <= ST_STOP_C;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_STOP_C: begin
               if (phase_done) begin
                  pc <= '0;
                  st <= ST_HOLD;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            ST_HOLD: begin
               if (bus_free)
                  st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      fault   = (st != ST_IDLE);
      scl_pd  = (st == ST_CLK_LO) || (st == ST_STOP_A) || (st == ST_STOP_B);
      sda_pd  = (st == ST_STOP_B) || (st == ST_STOP_C);
      acc_inh = (st == ST_CLK_LO) || (st == ST_CLK_HI) || (st == ST_STOP_A) ||
                (st == ST_STOP_B) || (st == ST_STOP_C);
   end
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
   parameter int STUCK_TICKS = 30000,
   parameter int GAP_TICKS   = 40,
   parameter int HALF_TICKS  = 59,
   parameter int NUM_PULSES  = 16,
   parameter int STOP_TICKS  = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic en_lvl,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic fault_o,
   output logic scl_pd_o,
   output logic sda_pd_o,
   output logic acc_inh_o
);
   localparam int NLINES = 2;

   generate
      if (STUCK_TICKS < 2) begin : g_bad_stuck
         $error("STUCK_TICKS must be at least 2");
      end
      if (GAP_TICKS < 1 || HALF_TICKS < 1 || STOP_TICKS < 1) begin : g_bad_phase
         $error("phase lengths must be at least 1");
      end
      if (NUM_PULSES < 1) begin : g_bad_pulses
         $error("NUM_PULSES must be at least 1");
      end
   endgenerate

   logic              en_d;
   logic              en_rise;
   logic [NLINES-1:0] line_lvl;
   logic [NLINES-1:0] line_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_d <= 1'b1;
      else        en_d <= en_lvl;
   end

   assign en_rise  = en_lvl & ~en_d;
   assign line_lvl = {sda_lvl, scl_lvl};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_line
         sbr_low_timer #(.LIMIT(STUCK_TICKS)) tmr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .restart  (en_rise),
            .line_lvl (line_lvl[i]),
            .expired  (line_exp[i])
         );
      end
   endgenerate

   sbr_recovery_fsm #(
      .GAP_TICKS  (GAP_TICKS),
      .HALF_TICKS (HALF_TICKS),
      .NUM_PULSES (NUM_PULSES),
      .STOP_TICKS (STOP_TICKS)
   ) fsm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .en_lvl  (en_lvl),
      .en_rise (en_rise),
      .stuck   (|line_exp),
      .scl_lvl (scl_lvl),
      .sda_lvl (sda_lvl),
      .fault   (fault_o),
      .scl_pd  (scl_pd_o),
      .sda_pd  (sda_pd_o),
      .acc_inh (acc_inh_o)
   );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic en_lvl,
   input logic scl_lvl,
   input logic sda_lvl,
   input logic fault_o,
   input logic scl_pd_o,
   input logic sda_pd_o,
   input logic acc_inh_o
);
   // R9: enable low quiets every output on the next edge
   a_r9_en_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl |=> (!fault_o && !scl_pd_o && !sda_pd_o && !acc_inh_o));

   // R11: accelerators inhibited whenever a pull-down is active
   a_r11_inhibit_covers_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_pd_o || sda_pd_o) |-> acc_inh_o);

   // R11: no inhibit outside a fault
   a_r11_no_inhibit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> !acc_inh_o);

   // R7: SDA is pulled low only after SCL is already low
   a_r7_sda_after_scl: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pd_o) |-> (scl_pd_o && $past(scl_pd_o)));

   // R7: SDA released last, with SCL already released
   a_r7_sda_release_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pd_o) |-> (!scl_pd_o && $past(!scl_pd_o)));

   // R12: with no tick and enable high nothing moves
   a_r12_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && en_lvl) |=> $stable({fault_o, scl_pd_o, sda_pd_o, acc_inh_o}));

   // R2: a fault only follows a low sample on a line
   a_r2_fault_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> $past(!scl_lvl || !sda_lvl, 2));
endmodule

bind stuck_bus_recovery sbr_checker chk_i (.*);

// File: tb/stuck_bus_recovery_tb_top.sv
module stuck_bus_recovery_tb_top;
   localparam int STK  = 20;
   localparam int GAP  = 4;
   localparam int HALF = 3;
   localparam int NP   = 16;
   localparam int STP  = 2;

   // rows: line (0 = SCL, 1 = SDA), release at pulse (0 = never), expected pulses
   localparam int NROWS = 6;
   localparam int ROW_TAB [NROWS][3] = '{
      '{1, 0, NP}, '{0, 0, NP}, '{1, 3, 3}, '{0, 5, 5}, '{1, 1, 1}, '{0, NP, NP}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b1;
   logic en_lvl = 1'b1;
   logic hold_scl = 1'b0;
   logic hold_sda = 1'b0;
   logic scl_lvl, sda_lvl;
   logic fault_o, scl_pd_o, sda_pd_o, acc_inh_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   assign scl_lvl = !(scl_pd_o || hold_scl);
   assign sda_lvl = !(sda_pd_o || hold_sda);

   always #4 clk = ~clk;

   stuck_bus_recovery #(
      .STUCK_TICKS (STK),
      .GAP_TICKS   (GAP),
      .HALF_TICKS  (HALF),
      .NUM_PULSES  (NP),
      .STOP_TICKS  (STP)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .en_lvl    (en_lvl),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .fault_o   (fault_o),
      .scl_pd_o  (scl_pd_o),
      .sda_pd_o  (sda_pd_o),
      .acc_inh_o (acc_inh_o)
   );

   // Port monitor: stop ordering and inhibit coverage
   int order_bad = 0;
   int inh_bad = 0;
   logic m_scl = 1'b0;
   logic m_sda = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_pd_o && !m_sda && !(scl_pd_o && m_scl)) order_bad++;
         if (!sda_pd_o && m_sda && (scl_pd_o || m_scl)) order_bad++;
         if ((scl_pd_o || sda_pd_o) && !acc_inh_o) inh_bad++;
         if (acc_inh_o && !fault_o) inh_bad++;
      end
      m_scl = scl_pd_o;
      m_sda = sda_pd_o;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_hold(input int line, input bit v);
      if (line == 0) hold_scl = v;
      else           hold_sda = v;
   endtask

   task automatic wait_fault(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!fault_o && n < 500);
   endtask

   task automatic settle();
      en_lvl = 1'b0;
      hold_scl = 1'b0;
      hold_sda = 1'b0;
      repeat (3) @(negedge clk);
      en_lvl = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic run_row(input int line, input int rel_at, input int exp_p);
      int n, g, ps, pulses, lo, hi, ob0, ib0, guard, busy;
      logic p_scl, p_sda;
      bit stop_seen;
      ob0 = order_bad;
      ib0 = inh_bad;
      set_hold(line, 1'b1);
      wait_fault(n);
      chk(n == STK + 1, "R2 fault latency", n, STK + 1);
      g = 0;
      while (!scl_pd_o && g < 200) begin
         @(negedge clk);
         g++;
      end
      chk(g == GAP, "R4 gap before first pulse", g, GAP);
      ps = 1; pulses = 0; lo = 1; hi = 0; stop_seen = 1'b0;
      if (rel_at == 1) set_hold(line, 1'b0);
      p_scl = scl_pd_o;
      p_sda = sda_pd_o;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (scl_pd_o && !p_scl && !sda_pd_o) begin
            ps++;
            if (ps == rel_at) set_hold(line, 1'b0);
         end
         if (!scl_pd_o && p_scl && !sda_pd_o) pulses++;
         if (pulses == 0 && scl_pd_o) lo++;
         if (pulses == 1 && !scl_pd_o && !sda_pd_o) hi++;
         if (!sda_pd_o && p_sda) begin
            stop_seen = 1'b1;
            break;
         end
         p_scl = scl_pd_o;
         p_sda = sda_pd_o;
      end
      chk(lo == HALF, "R5 low half length", lo, HALF);
      if (exp_p >= 2) chk(hi == HALF, "R5 high half length", hi, HALF);
      chk(pulses == exp_p, "R6 pulse count", pulses, exp_p);
      chk(stop_seen, "R7 stop issued", int'(stop_seen), 1);
      chk(order_bad == ob0, "R7 stop ordering", order_bad - ob0, 0);
      chk(inh_bad == ib0, "R11 inhibit coverage", inh_bad - ib0, 0);
      @(negedge clk);
      chk(fault_o == (rel_at == 0), "R8 fault after stop", int'(fault_o), int'(rel_at == 0));
      if (rel_at == 0) begin
         busy = 0;
         for (guard = 0; guard < 30; guard++) begin
            @(negedge clk);
            if (scl_pd_o || sda_pd_o || !fault_o) busy++;
         end
         chk(busy == 0, "R8 held fault without drive", busy, 0);
         set_hold(line, 1'b0);
         @(negedge clk);
         chk(!fault_o, "R8 fault clears on free bus", int'(fault_o), 0);
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int n, any;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!fault_o && !scl_pd_o && !sda_pd_o && !acc_inh_o, "R1 outputs in reset",
          int'({fault_o, scl_pd_o, sda_pd_o, acc_inh_o}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!fault_o && !scl_pd_o && !sda_pd_o && !acc_inh_o, "R1 outputs after reset",
          int'({fault_o, scl_pd_o, sda_pd_o, acc_inh_o}), 0);

      // Vector table of stuck/release patterns
      for (int r = 0; r < NROWS; r++) begin
         run_row(ROW_TAB[r][0], ROW_TAB[r][1], ROW_TAB[r][2]);
         settle();
      end

      // R3: one high sample clears the counter
      any = 0;
      hold_sda = 1'b1;
      repeat (STK - 1) begin
         @(negedge clk);
         if (fault_o) any++;
      end
      hold_sda = 1'b0;
      @(negedge clk);
      if (fault_o) any++;
      chk(any == 0, "R3 short low run no fault", any, 0);
      hold_sda = 1'b1;
      wait_fault(n);
      chk(n == STK + 1, "R3 counter restarted", n, STK + 1);
      settle();

      // R9 / R10: enable low cancels, rising edge restarts
      hold_sda = 1'b1;
      wait_fault(n);
      while (!scl_pd_o) @(negedge clk);
      en_lvl = 1'b0;
      @(negedge clk);
      chk(!fault_o && !scl_pd_o && !sda_pd_o && !acc_inh_o, "R9 cancel on enable low",
          int'({fault_o, scl_pd_o, sda_pd_o, acc_inh_o}), 0);
      any = 0;
      repeat (3 * STK) begin
         @(negedge clk);
         if (fault_o || scl_pd_o || sda_pd_o) any++;
      end
      chk(any == 0, "R9 no recovery while disabled", any, 0);
      en_lvl = 1'b1;
      wait_fault(n);
      chk(n == STK + 2, "R10 restart latency", n, STK + 2);
      settle();

      // R12: no tick, no progress
      tick_en = 1'b0;
      hold_sda = 1'b1;
      any = 0;
      repeat (3 * STK) begin
         @(negedge clk);
         if (fault_o) any++;
      end
      chk(any == 0, "R12 frozen without tick", any, 0);
      tick_en = 1'b1;
      wait_fault(n);
      chk(n == STK + 1, "R12 resumes with tick", n, STK + 1);
      settle();

      // R13: reset released into a stuck bus
      rst_n = 1'b0;
      hold_scl = 1'b1;
      repeat (3) @(negedge clk);
      chk(!fault_o, "R1 reset clears fault", int'(fault_o), 0);
      rst_n = 1'b1;
      wait_fault(n);
      chk(n == STK + 1, "R13 power-up into stuck bus", n, STK + 1);
      settle();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule